// File: doc/BRIEF.md
# Multi-Tau Correlation Exponent Scaler

This block sits at the tail of a multi-tau correlator's result path. Each result is a single-precision floating-point value, and the results arrive in lag order with a valid strobe. The pairwise-summing stages ahead of the correlator make each later group of lags four times larger per stage. The block removes that growth by dividing each value by a power of four chosen from the value's position in the current result set.

The block does not use a floating-point divider. Every divisor is a power of two, so the block subtracts a running decrement from the 8-bit exponent field. The sign bit and the 23-bit fraction pass through unchanged. The first sixteen results of a set are not scaled. Each later group of eight results is divided by a further factor of four, which takes 2 more off the exponent.

Results that would underflow become a signed zero. Zero and denormal inputs also become a signed zero. Infinities and NaNs (exponent 255) are passed through untouched. A synchronous reset, or a one-cycle start-of-set pulse, restarts the position schedule. The scaled value appears one clock after its strobe.

Top module: `mtau_exp_scaler`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `outValid` is 0 and `outData` is 0. The next valid input after reset is treated as index 0 of a new set.
- R2: The position within a set advances only on cycles with `inValid` high. Idle cycles between strobes do not move the schedule.
- R3: Results with index 0 to 15 of a set leave the block with the same bits as they entered, for exponents 1 to 254.
- R4: For index k of 16 or more, the exponent (bits 30:23) is reduced by 2·(floor(k/8) − 1), as long as the result stays at or above 1.
- R5: The sign bit (bit 31) of every result equals the sign bit of its input. For non-zero results, the fraction (bits 22:0) equals the input fraction.
- R6: `outValid` equals `inValid` delayed by exactly one clock. `outData` carries the result for the input strobed on the previous clock.
- R7: An input with exponent 0 (zero or denormal) gives a signed zero: bit 31 is kept and bits 30:0 are 0.
- R8: If the input exponent is at or below the current decrement, the output is a signed zero.
- R9: An input with exponent 255 (infinity or NaN) is output with all 32 bits unchanged, at any index.
- R10: A `setStart` pulse resets the position to the start of a new set. A valid strobe in the same cycle as the pulse is taken as index 0.
- R11: The decrement saturates at 255 and never wraps. Very long sets therefore drive every finite value to a signed zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| setStart | input | 1 | One-cycle pulse that starts a new result set |
| inValid | input | 1 | Strobe marking `inData` as a valid result |
| inData | input | 32 | Single-precision input value |
| outValid | output | 1 | Strobe marking `outData` as valid |
| outData | output | 32 | Scaled single-precision value |

## Verification
The case that is hardest to reach is the saturation of the decrement. It only happens after more than a thousand strobes without a restart. The bench drives one unbroken set of 1100 values with exponent 254. Past index 1032, an 8-bit wrap of the decrement would let a value through unchanged, while a saturated decrement gives zero, so the bench can tell the two apart. Start-of-set pulses that coincide with a strobe, and idle gaps inside a set, are driven on purpose so that any slip in the position count shows up as a wrong exponent. This is checked against a behavioural model that recomputes the expected result on every clock.

// File: rtl/mtau_scale_pkg.sv
package mtau_scale_pkg;
  localparam int DATA_W = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;

  typedef struct packed {
    logic             take;    // a valid value is being presented this cycle
    logic [EXP_W-1:0] decAmt;  // exponent decrement that applies to it
  } scaleCtl_t;
endpackage

// File: rtl/mtau_scale_ctrl.sv
module mtau_scale_ctrl
  import mtau_scale_pkg::*;
#(
  parameter int GROUP_LEN    = 8,
  parameter int FIRST_GROUPS = 2,
  parameter int STEP         = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      setStart,
  input  logic      inValid,
  output scaleCtl_t ctl
);
  localparam int CNT_W  = $clog2(GROUP_LEN);
  localparam int SKIP_W = $clog2(FIRST_GROUPS + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(GROUP_LEN - 1);
  localparam logic [SKIP_W-1:0] SKIP_LAST = SKIP_W'(FIRST_GROUPS - 1);
  localparam logic [EXP_W-1:0]  DEC_MAX   = '1;

  logic [CNT_W-1:0]  cnt, curCnt;
  logic [SKIP_W-1:0] skip, curSkip;
  logic [EXP_W-1:0]  dec, curDec, stepDec;
  logic [EXP_W:0]    decSum;
  logic              wrap;

  always_comb begin
    curCnt  = setStart ? '0 : cnt;
    curSkip = setStart ? '0 : skip;
    curDec  = setStart ? '0 : dec;
    wrap    = inValid && (curCnt == CNT_LAST);
    decSum  = {1'b0, curDec} + (EXP_W+1)'(STEP);
    stepDec = decSum[EXP_W] ? DEC_MAX : decSum[EXP_W-1:0];
    ctl.take   = inValid;
    ctl.decAmt = curDec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      skip <= '0;
      dec  <= '0;
    end else begin
      cnt  <= curCnt;
      skip <= curSkip;
      dec  <= curDec;
      if (inValid) cnt <= curCnt + CNT_W'(1);
      if (wrap) begin
        if (curSkip != SKIP_LAST) skip <= curSkip + SKIP_W'(1);
        else                      dec  <= stepDec;
      end
    end
  end

  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!inValid && !setStart) |=> $stable(cnt)); // R2

  AST_DEC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!setStart) |=> (dec >= $past(dec))); // R11

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (setStart && !inValid) |=> (dec == '0 && cnt == '0)); // R10
endmodule

// File: rtl/mtau_scale_dpath.sv
module mtau_scale_dpath
  import mtau_scale_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  scaleCtl_t         ctl,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  localparam logic [EXP_W-1:0] EXP_SPECIAL = '1;

  logic              sgn;
  logic [EXP_W-1:0]  expIn;
  logic [FRAC_W-1:0] fracIn;
  logic [DATA_W-1:0] nxtData;

  always_comb begin
    sgn    = inData[DATA_W-1];
    expIn  = inData[DATA_W-2 -: EXP_W];
    fracIn = inData[FRAC_W-1:0];
    if (expIn == EXP_SPECIAL)
      nxtData = inData;
    else if (expIn <= ctl.decAmt)
      nxtData = {sgn, {(DATA_W-1){1'b0}}};
    else
      nxtData = {sgn, expIn - ctl.decAmt, fracIn};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= ctl.take;
      if (ctl.take) outData <= nxtData;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ctl.take |=> outValid); // R6

  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !ctl.take |=> !outValid); // R6

  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (rst)
    ctl.take |=> (outData[DATA_W-1] == $past(inData[DATA_W-1]))); // R5

  AST_SPECIAL_PASS: assert property (@(posedge clk) disable iff (rst)
    (ctl.take && inData[DATA_W-2 -: EXP_W] == EXP_SPECIAL) |=> (outData == $past(inData))); // R9

  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
    (ctl.take && inData[DATA_W-2 -: EXP_W] == '0) |=> (outData[DATA_W-2:0] == '0)); // R7
endmodule

// File: rtl/mtau_exp_scaler.sv
module mtau_exp_scaler
  import mtau_scale_pkg::*;
#(
  parameter int GROUP_LEN    = 8,
  parameter int FIRST_GROUPS = 2,
  parameter int STEP         = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        setStart,
  input  logic        inValid,
  input  logic [31:0] inData,
  output logic        outValid,
  output logic [31:0] outData
);
  scaleCtl_t ctl;

  mtau_scale_ctrl #(
    .GROUP_LEN(GROUP_LEN),
    .FIRST_GROUPS(FIRST_GROUPS),
    .STEP(STEP)
  ) ctrlInst (
    .clk(clk),
    .rst(rst),
    .setStart(setStart),
    .inValid(inValid),
    .ctl(ctl)
  );

  mtau_scale_dpath dpathInst (
    .clk(clk),
    .rst(rst),
    .ctl(ctl),
    .inData(inData),
    .outValid(outValid),
    .outData(outData)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!outValid && outData == '0)); // R1
endmodule

// File: tb/mtau_exp_scaler_test.sv
module mtau_exp_scaler_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        setStart = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        outValid;
  logic [31:0] outData;

  mtau_exp_scaler uut (
    .clk(clk), .rst(rst), .setStart(setStart), .inValid(inValid),
    .inData(inData), .outValid(outValid), .outData(outData)
  );

  int nRun = 0;
  int nFail = 0;
  int idx = 0;
  bit expValid = 1'b0;
  logic [31:0] expData = '0;
  string expReq = "R6";
  string phase = "init";
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] refScale(input logic [31:0] d, input int k, output string tag);
    int dec;
    int e;
    dec = (k < 16) ? 0 : 2 * (k / 8 - 1);
    if (dec > 255) dec = 255;
    e = int'(d[30:23]);
    if (e == 255) begin tag = "R9"; return d; end
    if (e == 0) begin tag = "R7"; return {d[31], 31'b0}; end
    if (e <= dec) begin tag = (dec == 255) ? "R11" : "R8"; return {d[31], 31'b0}; end
    tag = (k < 16) ? "R3" : "R4";
    return {d[31], 8'(e - dec), d[22:0]};
  endfunction

  task automatic compare();
    nRun++;
    if (outValid !== expValid) begin
      nFail++;
      $display("FAIL R6 [%s] outValid=%b expected=%b", phase, outValid, expValid);
    end else if (expValid && outData !== expData) begin
      nFail++;
      $display("FAIL %s R5 [%s] outData=%h expected=%h", expReq, phase, outData, expData);
    end
  endtask

  // drive one cycle at a falling edge, check the result at the next one
  task automatic step(input bit st, input bit v, input logic [31:0] d);
    string tag;
    setStart = st;
    inValid  = v;
    inData   = d;
    if (st) idx = 0;
    expValid = v;
    if (v) begin
      expData = refScale(d, idx, tag);
      expReq  = tag;
      idx++;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic doReset();
    rst = 1'b1; setStart = 1'b0; inValid = 1'b0; inData = 32'hFFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    nRun++;
    if (outValid !== 1'b0 || outData !== 32'h0) begin
      nFail++;
      $display("FAIL R1 during reset outValid=%b outData=%h expected 0/0", outValid, outData);
    end
    rst = 1'b0; idx = 0; expValid = 1'b0;
    step(1'b0, 1'b0, 32'h0);
    nRun++;
    if (outData !== 32'h0) begin
      nFail++;
      $display("FAIL R1 after reset outData=%h expected 00000000", outData);
    end
  endtask

  function automatic logic [31:0] mkVal(input bit s, input int e, input logic [22:0] f);
    return {s, 8'(e), f};
  endfunction

  initial begin
    fork
      begin
        @(negedge clk);
        doReset();

        phase = "R3 R4 plain set";
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, mkVal(1'b0, 130, 23'(i * 977)));

        phase = "R10 start with strobe, R2 gaps";
        step(1'b1, 1'b1, mkVal(1'b1, 100, 23'h12345));
        for (int i = 1; i < 48; i++) begin
          step(1'b0, 1'b1, mkVal(i[0], 100, 23'(i * 31)));
          if (i % 3 == 0) begin
            step(1'b0, 1'b0, 32'hDEAD_BEEF);
            step(1'b0, 1'b0, 32'h0);
          end
        end

        phase = "R10 start without strobe";
        step(1'b1, 1'b0, 32'h0);
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, mkVal(1'b0, 90, 23'h7));

        phase = "R5 R7 R9 specials";
        step(1'b1, 1'b1, 32'h7F80_0000);
        step(1'b0, 1'b1, 32'hFFC0_0001);
        step(1'b0, 1'b1, 32'h8000_0000);
        step(1'b0, 1'b1, 32'h0000_0001);
        step(1'b0, 1'b1, 32'h8012_3456);
        for (int i = 5; i < 30; i++) begin
          seed = seed * 32'd1664525 + 32'd1013904223;
          case (seed[31:29])
            3'd0:    step(1'b0, 1'b1, {seed[0], 8'hFF, seed[22:0]});
            3'd1:    step(1'b0, 1'b1, {seed[0], 8'h00, seed[22:0]});
            default: step(1'b0, 1'b1, seed);
          endcase
        end

        phase = "R8 underflow";
        step(1'b1, 1'b1, mkVal(1'b0, 3, 23'h1));
        for (int i = 1; i < 40; i++) step(1'b0, 1'b1, mkVal(i[1], 3 + (i % 5), 23'h55));

        phase = "R11 saturation";
        step(1'b1, 1'b1, mkVal(1'b0, 254, 23'h1));
        for (int i = 1; i < 1100; i++) step(1'b0, 1'b1, mkVal(1'b0, 254, 23'h1));
        step(1'b0, 1'b1, 32'h7F80_0000);

        phase = "R1 reset mid set";
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, mkVal(1'b0, 120, 23'h3));
        doReset();
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, mkVal(1'b0, 120, 23'h3));
        step(1'b0, 1'b0, 32'h0);
      end
      begin
        repeat (200000) @(posedge clk);
        nRun++;
        nFail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule